// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the system clock into the time base of one CAN bit. A prescaler divides the clock into time quanta. A sequencer then walks each bit through four ordered segments: a one-quantum synchronisation segment, a propagation segment, a first phase segment and a second phase segment. The prescaler value and the quanta counts of the propagation and phase segments are programmable. The block outputs a quantum tick, the current segment, a sample strobe where phase segment 1 ends, and a transmit strobe where each bit begins.

A recessive-to-dominant edge indication from the bus lets the timing follow other nodes. While the bus is idle, an edge restarts the bit at once (hard sync). During a frame, an edge adjusts the current bit (soft resync). A late edge lengthens phase segment 1. An early edge, one that arrives in phase segment 2, shortens that segment. The size of either correction is limited by a programmable jump width. All settings are captured when a bit starts, so a change made in the middle of a bit leaves that bit unchanged.

Top module: `can_bit_timer`

## Requirements
- R1: While reset is held, `seg_o` is 0 and all strobes are low. The first clock edge after reset is released captures the settings and starts a bit, so `tx_point_o` is high in the clock after that edge.
- R2: `tq_tick_o` is high for one clock in every BRP clocks, in the last clock of each quantum. A bit holds 1+PROP+PH1+PH2 ticks.
- R3: Without resynchronisation, `tx_point_o` pulses for one clock every BRP*(1+PROP+PH1+PH2) clocks, and `seg_o` is 0 in that clock. The legal ranges are BRP 1..64, PROP 1..8, PH1 1..8, PH2 2..8 and SJW 1..4.
- R4: `seg_o` steps through the codes 0 (sync, one quantum), 1 (propagation, PROP quanta), 2 (phase 1, PH1 quanta) and 3 (phase 2, PH2 quanta), in that order.
- R5: `sample_o` pulses for one clock in the first clock of phase 2, that is BRP*(1+PROP+PH1) clocks after `tx_point_o`.
- R6: The settings are captured only when a bit starts. A change made during a bit takes effect from the next bit.
- R7: With `bus_idle_i` high, an edge on `rx_fall_i` in clock c restarts the bit: `tx_point_o` is high in clock c+1, and the new bit has nominal length.
- R8: With `bus_idle_i` low, an edge in quantum k of the bit, where 1 ≤ k ≤ PROP+PH1 and the sync quantum is quantum 0, lengthens phase 1 by min(k, SJW) quanta. This moves both the sample strobe and the end of the bit.
- R9: With `bus_idle_i` low, an edge in quantum k inside phase 2 leaves r = 1+PROP+PH1+PH2−k quanta. If r ≤ SJW, the next bit starts in the following clock. Otherwise phase 2 is shortened by SJW quanta.
- R10: An edge in the sync quantum has no effect. So does any edge after the first soft resync within the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brp_i | input | BRP_W (7) | Prescaler: system clocks per quantum, 1..64 |
| prop_i | input | SEG_W (4) | Propagation segment quanta, 1..8 |
| ph1_i | input | SEG_W (4) | Phase segment 1 quanta, 1..8 |
| ph2_i | input | SEG_W (4) | Phase segment 2 quanta, 2..8 |
| sjw_i | input | SJW_W (3) | Resync jump width in quanta, 1..4 |
| bus_idle_i | input | 1 | High while no frame is in progress (selects hard sync) |
| rx_fall_i | input | 1 | One-clock pulse on a recessive-to-dominant bus edge |
| tq_tick_o | output | 1 | Last clock of each time quantum |
| sample_o | output | 1 | Sample-point strobe (first clock of phase 2) |
| tx_point_o | output | 1 | Bit-start strobe (first clock of sync) |
| seg_o | output | 2 | Current segment: 0 sync, 1 prop, 2 phase 1, 3 phase 2 |

## Verification
The nominal path is tried with a grid of prescaler and segment settings, including the smallest and largest counts. For every clock of a bit, the bench compares the segment code, the tick, the sample strobe and the transmit strobe with positions computed from the settings, which catches off-by-one errors in any single counter. Resynchronisation is tried by placing one edge in each clock of a bit, with three jump widths. This separates edges in the sync quantum, late edges whose correction is capped by the jump width, and early edges that either shorten phase 2 or end the bit at once. Further runs cover a second edge in the same bit, hard sync at two points of a bit, and a change of settings in the middle of a bit.

// File: rtl/can_bt_pkg.sv
`timescale 1ns/1ps
package can_bt_pkg;
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;
endpackage

// File: rtl/can_bt_prescaler.sv
`timescale 1ns/1ps
module can_bt_prescaler #(
    parameter int BRP_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [BRP_W-1:0] brp_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [BRP_W-1:0] cnt;
    } pre_t;

    pre_t q, d;
    logic tick;

    always_comb begin
        d    = q;
        tick = (q.cnt == brp_i - BRP_W'(1)) && !restart_i;
        if (restart_i || tick) d.cnt = '0;
        else                   d.cnt = q.cnt + BRP_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick_o = tick;

    // R2: the divider never runs past the captured prescaler value
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < brp_i);
endmodule

// File: rtl/can_bt_seq.sv
`timescale 1ns/1ps
module can_bt_seq
    import can_bt_pkg::*;
#(
    parameter int BRP_W = 7,
    parameter int SEG_W = 4,
    parameter int SJW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             edge_i,
    input  logic             idle_i,
    input  logic [BRP_W-1:0] brp_i,
    input  logic [SEG_W-1:0] prop_i,
    input  logic [SEG_W-1:0] ph1_i,
    input  logic [SEG_W-1:0] ph2_i,
    input  logic [SJW_W-1:0] sjw_i,
    output logic             restart_o,
    output logic [BRP_W-1:0] brp_o,
    output seg_e             seg_o,
    output logic             sample_o,
    output logic             tx_o
);
    localparam int QW = SEG_W + 1;

    typedef struct packed {
        seg_e             seg;
        logic [QW-1:0]    qcnt;
        logic [BRP_W-1:0] brp;
        logic [SEG_W-1:0] prop;
        logic [SEG_W-1:0] ph1;
        logic [SEG_W-1:0] ph2;
        logic [SJW_W-1:0] sjw;
        logic [SJW_W-1:0] ext;
        logic [SJW_W-1:0] cut;
        logic             synced;
        logic             init;
        logic             sample;
        logic             tx;
    } seq_t;

    seq_t q, d;
    logic [QW-1:0]    seg_len, late_e, early_rem;
    logic [SJW_W-1:0] ext_n, cut_n;
    logic             last, hard, soft_ok, early_now, restart, bit_end;

    always_comb begin
        hard      = edge_i && idle_i && !q.init;
        soft_ok   = edge_i && !idle_i && !q.init && !q.synced && (q.seg != SEG_SYNC);
        late_e    = (q.seg == SEG_PROP) ? q.qcnt + QW'(1)
                                        : QW'(q.prop) + q.qcnt + QW'(1);
        early_rem = QW'(q.ph2) - q.qcnt;
        early_now = soft_ok && (q.seg == SEG_PH2) && (early_rem <= QW'(q.sjw));
        restart   = q.init || hard || early_now;

        ext_n = q.ext;
        cut_n = q.cut;
        if (soft_ok && (q.seg == SEG_PH2)) cut_n = q.sjw;
        else if (soft_ok) ext_n = (late_e > QW'(q.sjw)) ? q.sjw : SJW_W'(late_e);

        case (q.seg)
            SEG_SYNC: seg_len = QW'(1);
            SEG_PROP: seg_len = QW'(q.prop);
            SEG_PH1:  seg_len = QW'(q.ph1) + QW'(ext_n);
            default:  seg_len = QW'(q.ph2) - QW'(cut_n);
        endcase
        last    = (q.qcnt == seg_len - QW'(1));
        bit_end = tick_i && (q.seg == SEG_PH2) && last;

        d        = q;
        d.sample = 1'b0;
        d.tx     = 1'b0;
        if (restart || bit_end) begin
            d.seg    = SEG_SYNC;
            d.qcnt   = '0;
            d.brp    = brp_i;
            d.prop   = prop_i;
            d.ph1    = ph1_i;
            d.ph2    = ph2_i;
            d.sjw    = sjw_i;
            d.ext    = '0;
            d.cut    = '0;
            d.synced = 1'b0;
            d.init   = 1'b0;
            d.tx     = 1'b1;
        end else begin
            d.ext = ext_n;
            d.cut = cut_n;
            if (soft_ok) d.synced = 1'b1;
            if (tick_i) begin
                if (last) begin
                    d.qcnt = '0;
                    case (q.seg)
                        SEG_SYNC: d.seg = SEG_PROP;
                        SEG_PROP: d.seg = SEG_PH1;
                        default:  d.seg = SEG_PH2;
                    endcase
                end else begin
                    d.qcnt = q.qcnt + QW'(1);
                end
            end
            d.sample = tick_i && (q.seg == SEG_PH1) && last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.seg    <= SEG_SYNC;
            q.brp    <= BRP_W'(1);
            q.prop   <= SEG_W'(1);
            q.ph1    <= SEG_W'(1);
            q.ph2    <= SEG_W'(2);
            q.sjw    <= SJW_W'(1);
            q.init   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign restart_o = restart;
    assign brp_o     = q.brp;
    assign seg_o     = q.seg;
    assign sample_o  = q.sample;
    assign tx_o      = q.tx;

    // R5: the sample strobe only ever appears in phase 2
    assert_sample_in_ph2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.sample |-> (q.seg == SEG_PH2));
    // R3: a bit start is always the first quantum of sync
    assert_tx_at_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.tx |-> (q.seg == SEG_SYNC) && (q.qcnt == '0));
    // R4: the segment only moves on a quantum tick or a restart
    assert_seg_moves_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart) |=> $stable(q.seg));
    // R8: the phase 1 extension never exceeds the jump width
    assert_ext_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.ext <= q.sjw);
    // R9: the phase 2 cut never exceeds the jump width
    assert_cut_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.cut <= q.sjw);
endmodule

// File: rtl/can_bit_timer.sv
`timescale 1ns/1ps
module can_bit_timer
    import can_bt_pkg::*;
#(
    parameter int BRP_W = 7,
    parameter int SEG_W = 4,
    parameter int SJW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] brp_i,
    input  logic [SEG_W-1:0] prop_i,
    input  logic [SEG_W-1:0] ph1_i,
    input  logic [SEG_W-1:0] ph2_i,
    input  logic [SJW_W-1:0] sjw_i,
    input  logic             bus_idle_i,
    input  logic             rx_fall_i,
    output logic             tq_tick_o,
    output logic             sample_o,
    output logic             tx_point_o,
    output logic [1:0]       seg_o
);
    logic             tick_w, restart_w;
    logic [BRP_W-1:0] brp_w;
    seg_e             seg_w;

    can_bt_prescaler #(.BRP_W(BRP_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart_w),
        .brp_i     (brp_w),
        .tick_o    (tick_w)
    );

    can_bt_seq #(.BRP_W(BRP_W), .SEG_W(SEG_W), .SJW_W(SJW_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_w),
        .edge_i    (rx_fall_i),
        .idle_i    (bus_idle_i),
        .brp_i     (brp_i),
        .prop_i    (prop_i),
        .ph1_i     (ph1_i),
        .ph2_i     (ph2_i),
        .sjw_i     (sjw_i),
        .restart_o (restart_w),
        .brp_o     (brp_w),
        .seg_o     (seg_w),
        .sample_o  (sample_o),
        .tx_o      (tx_point_o)
    );

    assign tq_tick_o = tick_w;
    assign seg_o     = seg_w;

    // R5: sample and bit-start strobes never coincide
    assert_strobes_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_o && tx_point_o));
    // R2: a bit start is never also the end of a quantum unless BRP is one
    assert_tick_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_point_o && tq_tick_o) |-> (brp_w == BRP_W'(1)));
endmodule

// File: tb/can_bit_timer_tb.sv
`timescale 1ns/1ps
module can_bit_timer_tb;
    localparam int BRP_W = 7;
    localparam int SEG_W = 4;
    localparam int SJW_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [BRP_W-1:0] brp_i = '0;
    logic [SEG_W-1:0] prop_i = '0, ph1_i = '0, ph2_i = '0;
    logic [SJW_W-1:0] sjw_i = '0;
    logic             bus_idle_i = 1'b0, rx_fall_i = 1'b0;
    logic             tq_tick_o, sample_o, tx_point_o;
    logic [1:0]       seg_o;

    int cyc = 0;
    int last_smp = -1;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (sample_o) last_smp = cyc;

    can_bit_timer #(.BRP_W(BRP_W), .SEG_W(SEG_W), .SJW_W(SJW_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .brp_i(brp_i), .prop_i(prop_i), .ph1_i(ph1_i),
        .ph2_i(ph2_i), .sjw_i(sjw_i), .bus_idle_i(bus_idle_i), .rx_fall_i(rx_fall_i),
        .tq_tick_o(tq_tick_o), .sample_o(sample_o), .tx_point_o(tx_point_o), .seg_o(seg_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int b, input int p, input int a, input int c, input int s);
        brp_i = BRP_W'(b); prop_i = SEG_W'(p); ph1_i = SEG_W'(a);
        ph2_i = SEG_W'(c); sjw_i = SJW_W'(s);
    endtask

    task automatic wait_tx_next(output int t);
        do @(negedge clk); while (!tx_point_o);
        t = cyc;
    endtask

    task automatic edge_at(input int n);
        while (cyc < n) @(negedge clk);
        rx_fall_i = 1'b1;
        @(negedge clk);
        rx_fall_i = 1'b0;
    endtask

    // Called at a negedge where tx_point_o is high; checks every clock of the bit.
    task automatic run_bit(input int b, input int p, input int a, input int c);
        int len = b * (1 + p + a + c);
        bit bs = 0, bt = 0, bm = 0, bx = 0;
        int as_ = 0, es = 0, at = 0, et = 0, am = 0, em = 0, ax = 0, ex = 0;
        for (int o = 0; o < len; o++) begin
            int qi = o / b;
            int eseg = (qi == 0) ? 0 : (qi <= p) ? 1 : (qi <= p + a) ? 2 : 3;
            int etk  = ((o % b) == b - 1) ? 1 : 0;
            int esm  = (o == b * (1 + p + a)) ? 1 : 0;
            int etx  = (o == 0) ? 1 : 0;
            if (!bs && int'(seg_o) != eseg)      begin bs = 1; as_ = int'(seg_o); es = eseg; end
            if (!bt && int'(tq_tick_o) != etk)   begin bt = 1; at = int'(tq_tick_o); et = etk; end
            if (!bm && int'(sample_o) != esm)    begin bm = 1; am = int'(sample_o); em = esm; end
            if (!bx && int'(tx_point_o) != etx)  begin bx = 1; ax = int'(tx_point_o); ex = etx; end
            @(negedge clk);
        end
        chk(!bs, "R4 segment sequence", as_, es);
        chk(!bt, "R2 quantum tick", at, et);
        chk(!bm, "R5 sample point", am, em);
        chk(!bx, "R3 bit start strobe", ax, ex);
        chk(tx_point_o === 1'b1, "R3 bit length", int'(tx_point_o), 1);
    endtask

    task automatic resync_case(input int off, input int sj);
        int t1, t2, k, adj, rem, eper, esmp;
        string tag;
        k = off / 2;
        esmp = 12;
        if (k == 0) begin
            eper = 18; tag = "R10 edge in sync";
        end else if (k <= 5) begin
            adj = (k < sj) ? k : sj;
            eper = 2 * (9 + adj); esmp = 2 * (6 + adj); tag = "R8 late edge";
        end else begin
            rem = 9 - k;
            eper = (rem <= sj) ? off + 1 : 2 * (9 - sj); tag = "R9 early edge";
        end
        sjw_i = SJW_W'(sj);
        wait_tx_next(t1);
        edge_at(t1 + off);
        if (tx_point_o) t2 = cyc;
        else            wait_tx_next(t2);
        chk(t2 - t1 == eper, {tag, " period"}, t2 - t1, eper);
        chk(last_smp - t1 == esmp, {tag, " sample"}, last_smp - t1, esmp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int t1, t2;
        int bl[3] = '{1, 2, 3};
        int pl[3] = '{1, 3, 8};
        int al[3] = '{1, 4, 8};
        int cl[3] = '{2, 5, 8};
        int sl[3] = '{1, 2, 4};
        set_cfg(2, 2, 3, 3, 1);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(seg_o == 2'd0, "R1 reset segment", int'(seg_o), 0);
        chk({tq_tick_o, sample_o, tx_point_o} == 3'b000, "R1 reset strobes",
            int'({tq_tick_o, sample_o, tx_point_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_point_o === 1'b1, "R1 first bit start", int'(tx_point_o), 1);
        run_bit(2, 2, 3, 3);

        // R2 R3 R4 R5: sweep of nominal settings
        foreach (bl[i]) foreach (pl[j]) foreach (al[m]) foreach (cl[n]) begin
            set_cfg(bl[i], pl[j], al[m], cl[n], 1);
            wait_tx_next(t1);
            run_bit(bl[i], pl[j], al[m], cl[n]);
        end

        // R6: mid-bit change applies only to the next bit
        set_cfg(2, 2, 3, 3, 1);
        wait_tx_next(t1);
        wait_tx_next(t1);
        repeat (3) @(negedge clk);
        set_cfg(3, 1, 1, 2, 1);
        wait_tx_next(t2);
        chk(t2 - t1 == 18, "R6 current bit unchanged", t2 - t1, 18);
        run_bit(3, 1, 1, 2);

        // R8 R9 R10: one edge at every clock of a bit, three jump widths
        set_cfg(2, 2, 3, 3, 1);
        wait_tx_next(t1);
        foreach (sl[s]) for (int off = 1; off < 18; off++) resync_case(off, sl[s]);

        // R10: second edge in the same bit is ignored
        sjw_i = SJW_W'(1);
        wait_tx_next(t1);
        wait_tx_next(t1);
        edge_at(t1 + 2);
        edge_at(t1 + 6);
        wait_tx_next(t2);
        chk(t2 - t1 == 20, "R10 second edge ignored", t2 - t1, 20);

        // R7: hard sync while idle
        bus_idle_i = 1'b1;
        wait_tx_next(t1);
        edge_at(t1 + 5);
        chk(tx_point_o === 1'b1 && cyc == t1 + 6, "R7 hard sync early", cyc - t1, 6);
        run_bit(2, 2, 3, 3);
        t1 = cyc;
        edge_at(t1 + 15);
        chk(tx_point_o === 1'b1 && cyc == t1 + 16, "R7 hard sync late", cyc - t1, 16);
        run_bit(2, 2, 3, 3);
        bus_idle_i = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule